// File: doc/BRIEF.md
# Saturating Acceleration Output Formatter

This block takes a wide signed result from an upstream filter and turns it into a 10-bit two's-complement word that a serial interface reads. Each sample arrives with a valid strobe. Two status inputs from the upstream datapath come with it. The overflow input is raised when the filter has reached the largest value its decimation stage can emit. The overrange input is raised when the signal is past full scale but the datapath can still compute it. Six codes at the two ends of the output range are kept back. Two of them are never produced. The other four report the sign and the kind of out-of-range event. Every other code carries acceleration data. Data that lies outside the usable span and has no status flag is clipped to the nearest data code.

A capture/hold input lets the system freeze the output word, for example so that several sensors can be sampled at one instant. The hold input first passes through a two-flop synchronizer. While the synchronized hold is high, new samples are not written into the output register, but they keep arriving. When hold drops again, the next valid sample is written as usual.

Top module: `accel_fmt_top`

## Requirements
- R1: When in_valid is high, hold is not in effect, neither flag is set, and in_data lies between -509 and +508, out_word becomes the low 10 bits of in_data at that clock edge. For example, 0 gives 0x000 and -1 gives 0x3FF.
- R2: out_word never takes the reserved codes +511 (0x1FF) or -512 (0x200).
- R3: A loaded sample with ovf_flag high gives +510 (0x1FE) when in_data is zero or positive. It gives -511 (0x201) when in_data is negative.
- R4: A loaded sample with ovr_flag high and ovf_flag low gives +509 (0x1FD) when in_data is zero or positive. It gives -510 (0x202) when in_data is negative.
- R5: When ovf_flag and ovr_flag are both high in one sample, the overflow code from R3 is produced.
- R6: A loaded sample with no flag set and in_data above +508 gives +508 (0x1FC). With in_data below -509 it gives -509 (0x203).
- R7: out_word changes only at a clock edge where in_valid is high. Otherwise it keeps its value.
- R8: While the synchronized hold is high, out_word keeps the last value that was loaded, whatever the data and flags presented.
- R9: hold_in is synchronized by two flops. Valid samples at the first two rising edges after hold_in rises are still loaded, and the third is blocked. After hold_in falls, samples at the first two edges are still blocked, and the third is loaded.
- R10: While rst_n is low, out_word is 0x000 and the hold synchronizer is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Strobe for a new filter result |
| in_data | input | IN_W (16) | Signed filter result |
| ovf_flag | input | 1 | Upstream overflow status for this sample |
| ovr_flag | input | 1 | Upstream overrange status for this sample |
| hold_in | input | 1 | Asynchronous capture/hold request |
| out_word | output | OUT_W (10) | Formatted two's-complement output register |

## Verification
Two functions can act at the same clock edge: the synchronized hold taking effect, and the loading of a sample that carries a status flag. The bench raises hold_in half a cycle before an edge. It then presents overflow and overrange samples at the edges where the synchronizer output changes, in both directions. At each of these edges it checks out_word: the flagged code must appear on the last two edges at which loading is still allowed and at the first edge after release, and the value must stay frozen everywhere in between. Overflow and overrange flags raised together on one sample are also covered by R5 vectors of both signs.

// File: rtl/accel_fmt_pkg.sv
package accel_fmt_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_OVR  = 2'd1,
      SEL_OVF  = 2'd2
   } fmt_sel_e;

   // Largest positive value of a w-bit two's-complement word
   function automatic int top_code(input int w);
      return (2 ** (w - 1)) - 1;
   endfunction

   // Overflow wins over overrange
   function automatic fmt_sel_e pick_sel(input logic ovf, input logic ovr);
      if (ovf)      return SEL_OVF;
      else if (ovr) return SEL_OVR;
      else          return SEL_DATA;
   endfunction

endpackage

// File: rtl/accel_fmt_sync.sv
module accel_fmt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("accel_fmt_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];

   // R10: synchronizer output is low straight after reset release
   p_sync_reset_r10: assert property (@(posedge clk) $rose(rst_n) |-> !dout)
      else $error("p_sync_reset_r10");
endmodule

// File: rtl/accel_fmt_map.sv
module accel_fmt_map
   import accel_fmt_pkg::*;
#(
   parameter int IN_W  = 16,
   parameter int OUT_W = 10
) (
   input  logic signed [IN_W-1:0]  in_data,
   input  logic                    ovf,
   input  logic                    ovr,
   output logic        [OUT_W-1:0] code
);
   localparam int TOP     = top_code(OUT_W);
   localparam int DATA_HI = TOP - 3;
   localparam int DATA_LO = -TOP + 2;

   localparam logic [OUT_W-1:0] C_OVF_P = OUT_W'(TOP - 1);
   localparam logic [OUT_W-1:0] C_OVR_P = OUT_W'(TOP - 2);
   localparam logic [OUT_W-1:0] C_HI    = OUT_W'(DATA_HI);
   localparam logic [OUT_W-1:0] C_LO    = OUT_W'(DATA_LO);
   localparam logic [OUT_W-1:0] C_OVR_N = OUT_W'(-TOP + 1);
   localparam logic [OUT_W-1:0] C_OVF_N = OUT_W'(-TOP);

   localparam logic signed [IN_W-1:0] LIM_HI = IN_W'(DATA_HI);
   localparam logic signed [IN_W-1:0] LIM_LO = IN_W'(DATA_LO);

   if (OUT_W < 4) begin : g_bad_out
      $error("accel_fmt_map: OUT_W must be at least 4");
   end
   if (IN_W < OUT_W) begin : g_bad_in
      $error("accel_fmt_map: IN_W must not be narrower than OUT_W");
   end

   logic     neg;
   fmt_sel_e sel;

   always_comb begin
      neg = in_data[IN_W-1];
      sel = pick_sel(ovf, ovr);
      unique case (sel)
         SEL_OVF: code = neg ? C_OVF_N : C_OVF_P;
         SEL_OVR: code = neg ? C_OVR_N : C_OVR_P;
         default: begin
            if (in_data > LIM_HI)      code = C_HI;
            else if (in_data < LIM_LO) code = C_LO;
            else                       code = in_data[OUT_W-1:0];
         end
      endcase
   end

   // R2: the map never emits either reserved code
   always_comb begin
      p_map_no_reserved_r2: assert (code !== OUT_W'(TOP) && code !== OUT_W'(-TOP - 1) || $isunknown(code));
   end
endmodule

// File: rtl/accel_fmt_hold_reg.sv
module accel_fmt_hold_reg #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         hold,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] RES_P = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] RES_N = {1'b1, {(W-1){1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             q <= '0;
      else if (load && !hold) q <= d;
   end

   // R8: a cycle under hold leaves the register untouched
   p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hold) |-> $stable(q)) else $error("p_hold_freeze_r8");

   // R7: no strobe, no change
   p_idle_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> $stable(q)) else $error("p_idle_keep_r7");

   // R2: reserved codes never reach the register
   p_no_reserved_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q != RES_P) && (q != RES_N)) else $error("p_no_reserved_r2");
endmodule

// File: rtl/accel_fmt_top.sv
module accel_fmt_top
   import accel_fmt_pkg::*;
#(
   parameter int IN_W        = 16,
   parameter int OUT_W       = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic signed [IN_W-1:0]  in_data,
   input  logic                    ovf_flag,
   input  logic                    ovr_flag,
   input  logic                    hold_in,
   output logic        [OUT_W-1:0] out_word
);
   localparam int TOP = top_code(OUT_W);
   localparam logic signed [IN_W-1:0] LIM_HI = IN_W'(TOP - 3);
   localparam logic signed [IN_W-1:0] LIM_LO = IN_W'(-TOP + 2);

   logic             hold_sync;
   logic [OUT_W-1:0] mapped;

   accel_fmt_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (hold_in),
      .dout (hold_sync)
   );

   accel_fmt_map #(.IN_W(IN_W), .OUT_W(OUT_W)) i_map (
      .in_data(in_data),
      .ovf    (ovf_flag),
      .ovr    (ovr_flag),
      .code   (mapped)
   );

   accel_fmt_hold_reg #(.W(OUT_W)) i_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .load (in_valid),
      .hold (hold_sync),
      .d    (mapped),
      .q    (out_word)
   );

   logic take;
   assign take = in_valid && !hold_sync;

   // R1: in-range data passes through unchanged
   p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take && !ovf_flag && !ovr_flag && (in_data <= LIM_HI) && (in_data >= LIM_LO)
      |=> out_word == $past(in_data[OUT_W-1:0])) else $error("p_pass_r1");

   // R3, R5: overflow code, chosen ahead of overrange
   p_ovf_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      take && ovf_flag |=> out_word == ($past(in_data[IN_W-1]) ? OUT_W'(-TOP) : OUT_W'(TOP - 1)))
      else $error("p_ovf_first_r5");

   // R4: overrange code by sign
   p_ovr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take && !ovf_flag && ovr_flag |=> out_word == ($past(in_data[IN_W-1]) ? OUT_W'(-TOP + 1) : OUT_W'(TOP - 2)))
      else $error("p_ovr_r4");

   // R6: unflagged data past the usable span is clipped
   p_clamp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take && !ovf_flag && !ovr_flag && (in_data > LIM_HI) |=> out_word == OUT_W'(TOP - 3))
      else $error("p_clamp_r6");
endmodule

// File: tb/test_accel_fmt_top.sv
module test_accel_fmt_top;
   localparam int CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic signed [15:0] in_data = '0;
   logic              ovf_flag = 1'b0;
   logic              ovr_flag = 1'b0;
   logic              hold_in = 1'b0;
   logic [9:0]        out_word;

   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   accel_fmt_top i_accel_fmt_top (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .ovf_flag(ovf_flag), .ovr_flag(ovr_flag), .hold_in(hold_in), .out_word(out_word)
   );

   // {req[3:0], ovf, ovr, data[15:0], expected[9:0]}
   localparam int NV = 18;
   localparam logic [31:0] VEC [NV] = '{
      {4'd1, 1'b0, 1'b0, 16'h0000, 10'h000},  // R1 zero
      {4'd1, 1'b0, 1'b0, 16'h0001, 10'h001},  // R1
      {4'd1, 1'b0, 1'b0, 16'hFFFF, 10'h3FF},  // R1 -1
      {4'd1, 1'b0, 1'b0, 16'h01FC, 10'h1FC},  // R1 +508
      {4'd1, 1'b0, 1'b0, 16'hFE03, 10'h203},  // R1 -509
      {4'd6, 1'b0, 1'b0, 16'h01FD, 10'h1FC},  // R6 +509
      {4'd6, 1'b0, 1'b0, 16'h03E8, 10'h1FC},  // R6 +1000
      {4'd6, 1'b0, 1'b0, 16'h7FFF, 10'h1FC},  // R6 max
      {4'd6, 1'b0, 1'b0, 16'hFE02, 10'h203},  // R6 -510
      {4'd6, 1'b0, 1'b0, 16'h8000, 10'h203},  // R6 min
      {4'd4, 1'b0, 1'b1, 16'h0258, 10'h1FD},  // R4 +600
      {4'd4, 1'b0, 1'b1, 16'hFDA8, 10'h202},  // R4 -600
      {4'd3, 1'b1, 1'b0, 16'h02BC, 10'h1FE},  // R3 +700
      {4'd3, 1'b1, 1'b0, 16'hFD44, 10'h201},  // R3 -700
      {4'd3, 1'b1, 1'b0, 16'h0000, 10'h1FE},  // R3 zero counts as positive
      {4'd5, 1'b1, 1'b1, 16'h02BC, 10'h1FE},  // R5 positive
      {4'd5, 1'b1, 1'b1, 16'hFFFB, 10'h201},  // R5 negative
      {4'd2, 1'b0, 1'b0, 16'h01FF, 10'h1FC}   // R2 +511 input never passes
   };

   task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: out_word=%h expected %h", tag, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic drive(input logic [15:0] d, input logic f, input logic r, input logic v);
      in_data = d; ovf_flag = f; ovr_flag = r; in_valid = v;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_word, 10'h000, "R10 reset value");
      rst_n = 1'b1;
      @(negedge clk);
      check(out_word, 10'h000, "R10 after release");

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][25:10], VEC[i][27], VEC[i][26], 1'b1);
         check(out_word, VEC[i][9:0], $sformatf("R%0d vector %0d", VEC[i][31:28], i));
         checks++;
         if (out_word == 10'h1FF || out_word == 10'h200) begin
            errors++;
            $display("FAIL R2 vector %0d: out_word=%h expected non-reserved", i, out_word);
         end
      end

      // R7: no strobe means no update
      drive(16'h0005, 1'b0, 1'b0, 1'b1);
      check(out_word, 10'h005, "R7 load");
      drive(16'h0123, 1'b1, 1'b0, 1'b0);
      check(out_word, 10'h005, "R7 idle ignored");

      // R9: raise hold; two more edges still load, third blocked
      hold_in = 1'b1;
      drive(16'h02BC, 1'b1, 1'b0, 1'b1);
      check(out_word, 10'h1FE, "R9 first edge after rise loads");
      drive(16'hFDA8, 1'b0, 1'b1, 1'b1);
      check(out_word, 10'h202, "R9 second edge after rise loads");
      drive(16'h0007, 1'b0, 1'b0, 1'b1);
      check(out_word, 10'h202, "R9 third edge blocked");
      // R8: held value survives data and flags
      drive(16'hFD44, 1'b1, 1'b1, 1'b1);
      check(out_word, 10'h202, "R8 overflow ignored under hold");
      drive(16'h03E8, 1'b0, 1'b0, 1'b1);
      check(out_word, 10'h202, "R8 data ignored under hold");

      // R9: release; two edges still blocked, third loads
      hold_in = 1'b0;
      drive(16'h0011, 1'b0, 1'b0, 1'b1);
      check(out_word, 10'h202, "R9 first edge after fall blocked");
      drive(16'h0022, 1'b0, 1'b0, 1'b1);
      check(out_word, 10'h202, "R9 second edge after fall blocked");
      drive(16'hFD44, 1'b1, 1'b0, 1'b1);
      check(out_word, 10'h201, "R9 third edge after fall loads");

      // R10: reset mid-run clears output and synchronizer
      hold_in = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(out_word, 10'h000, "R10 reset clears output");
      hold_in = 1'b0;
      rst_n = 1'b1;
      drive(16'h0033, 1'b0, 1'b0, 1'b1);
      check(out_word, 10'h033, "R10 hold synchronizer cleared");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule